// File: doc/BRIEF.md
# Random Match Index Shuffler

This block holds a list of indexes that point into a separately stored table of matched feature-point pairs. A model-fitting engine needs four matches at a time, chosen at random. The block never moves the coordinate data. It reorders only its own index list, using two passes. The first pass is a perfect riffle: the list is cut into two halves and the halves are merged in strict alternation. The second pass reorders each complete group of four entries by one of eight fixed four-element permutations. The permutation choice comes from a 4-bit multiple-input signature register (MISR). Software or the memory controller feeds that register with the low nibble of each coordinate word read from memory.

A load pulse sets the list to identity order and latches the number of valid points. Each start pulse runs one riffle and one permutation pass on the current list, so repeated starts compound the shuffle. When the passes finish, the block raises a one-cycle done pulse. It then streams the first four entries of the list as read addresses over a valid/ready interface.

Back-pressure rules for the sample stream are as follows. A beat transfers on a rising clock edge where both valid and ready are high. While valid is high and ready is low, the index held on the output stays unchanged. Valid never drops before its beat has been taken. Load and start are plain control pulses, and the block acts on them only while it is idle.

Top module: `match_idx_shuffler`

## Requirements
- R1: On reset and on a load accepted in idle, entry i holds value i for every entry. The point count is latched at load, clamped to DEPTH. Load and start act only in idle, and load wins over start. A load or start given while a pass or a stream is in progress has no effect on the list or on the count.
- R2: The MISR is 4 bits wide and resets to 4'b0001. On every cycle with nib_vld_i high it becomes {s[2:0], s[3]^s[2]} XOR nib_i. Otherwise it holds its value.
- R3: The riffle pass uses the latched count n and h = floor(n/2). For i < h, entry 2i takes old entry i and entry 2i+1 takes old entry h+i. When n is odd, the last entry n-1 stays in place. Entries at or above n are never changed.
- R4: The permutation pass takes a 3-bit value snap, which is the low three bits of the MISR in the cycle the start is accepted. Group g covers entries 4g to 4g+3 and is reordered only if 4g+4 <= n. Its selector is s = snap XOR (g mod 8). New lane k takes old lane P[s][k]. The table P for s = 0 to 7 is: (0,1,2,3), (1,0,3,2), (2,3,0,1), (3,2,1,0), (1,2,3,0), (3,0,1,2), (0,2,1,3), (2,0,3,1). Entries in incomplete groups are left unchanged.
- R5: A start with no load before it works on the result of the previous shuffle, so the passes accumulate.
- R6: A start accepted at clock edge k produces done_o high for exactly one cycle, after edge k+2. That done cycle is also the first cycle of smp_valid_o.
- R7: After done_o, entries 0, 1, 2 and 3 are presented in order on smp_idx_o, one per accepted beat. While ready is low, valid and the index hold steady. After the fourth beat the block returns to idle.
- R8: Out of reset, smp_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Reset list to identity and latch the count |
| pt_count_i | input | CNT_W | Number of stored match points |
| start_i | input | 1 | Run one riffle and one permutation pass, then stream a sample |
| nib_vld_i | input | 1 | A coordinate word was read; fold its nibble into the MISR |
| nib_i | input | 4 | Low four bits of the coordinate word |
| done_o | output | 1 | One-cycle pulse when the shuffle passes are complete |
| smp_valid_o | output | 1 | Sample index valid |
| smp_ready_i | input | 1 | Consumer accepts the sample index |
| smp_idx_o | output | IDX_W | Sample index (read address into the point table) |

## Verification
The bound checker watches the following on every cycle. A stalled beat keeps its index. Done is a single pulse that always coincides with a valid output, and valid only rises together with done. The MISR moves only when a nibble arrives. The latched count stays fixed during a stream, and any sampled index lies inside the list. Only the bench scenarios show the actual orderings: the riffle with even, odd and clamped counts, the permutation chosen by the seeded MISR, the build-up over repeated shuffles, and the ignoring of a load and a start given while a stream is stalled. The bench computes these from the requirement formulas and compares them beat by beat.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RIFFLE,
    ST_PERM,
    ST_STREAM
  } seq_state_t;

  // Packed source-lane map: bits [2k+1:2k] name the old lane feeding new lane k.
  function automatic logic [7:0] lane_map(input logic [2:0] sel);
    logic [7:0] m;
    case (sel)
      3'd0: m = {2'd3, 2'd2, 2'd1, 2'd0};
      3'd1: m = {2'd2, 2'd3, 2'd0, 2'd1};
      3'd2: m = {2'd1, 2'd0, 2'd3, 2'd2};
      3'd3: m = {2'd0, 2'd1, 2'd2, 2'd3};
      3'd4: m = {2'd0, 2'd3, 2'd2, 2'd1};
      3'd5: m = {2'd2, 2'd1, 2'd0, 2'd3};
      3'd6: m = {2'd3, 2'd1, 2'd2, 2'd0};
      default: m = {2'd1, 2'd3, 2'd0, 2'd2};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sig_reg4.sv
module sig_reg4 #(
  parameter logic [3:0] SEED = 4'b0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [3:0] in_nib,
  output logic [3:0] state_o
);
  logic [3:0] sr_q;
  logic       fb;

  assign fb = sr_q[3] ^ sr_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= SEED;
    else if (in_vld) sr_q <= {sr_q[2:0], fb} ^ in_nib;
  end

  assign state_o = sr_q;
endmodule

// File: rtl/idx_file.sv
module idx_file #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_load,
  input  logic             do_riffle,
  input  logic             do_perm,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       sel_i,
  input  logic [1:0]       rd_addr,
  output logic [IDX_W-1:0] rd_data
);
  import shuf_pkg::*;

  logic [IDX_W-1:0] cur [DEPTH];
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] pair_end;

  assign half     = cnt_i >> 1;
  assign pair_end = {cnt_i[CNT_W-1:1], 1'b0};

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    localparam int GRP  = j / 4;
    localparam int LANE = j % 4;

    logic [IDX_W-1:0] q;
    logic [IDX_W-1:0] riffle_v;
    logic [IDX_W-1:0] perm_v;
    logic [CNT_W-1:0] hi_src;
    logic [7:0]       map;
    logic [1:0]       lane_src;

    // riffle source: even slots from low half, odd slots from high half
    always_comb begin
      hi_src = half + CNT_W'(j / 2);
      if (CNT_W'(j) < pair_end) begin
        if ((j % 2) == 0) riffle_v = cur[j / 2];
        else              riffle_v = cur[hi_src[IDX_W-1:0]];
      end else begin
        riffle_v = q;
      end
    end

    // group permutation: selector varies per group via group number
    always_comb begin
      map      = lane_map(sel_i ^ 3'(GRP % 8));
      lane_src = map[2*LANE +: 2];
      if (CNT_W'(4*GRP + 4) <= cnt_i)
        perm_v = cur[IDX_W'(4*GRP) + IDX_W'(lane_src)];
      else
        perm_v = q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         q <= IDX_W'(j);
      else if (do_load)   q <= IDX_W'(j);
      else if (do_riffle) q <= riffle_v;
      else if (do_perm)   q <= perm_v;
    end

    assign cur[j] = q;
  end

  assign rd_data = cur[IDX_W'(rd_addr)];
endmodule

// File: rtl/shuf_seq.sv
module shuf_seq #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       rng_i,
  input  logic             ready_i,
  output logic             do_load,
  output logic             do_riffle,
  output logic             do_perm,
  output logic [CNT_W-1:0] cnt_o,
  output logic [2:0]       sel_o,
  output logic [1:0]       beat_o,
  output logic             valid_o,
  output logic             done_o
);
  import shuf_pkg::*;

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       sel_q;
  logic [1:0]       beat_q;
  logic             done_q;
  logic [CNT_W-1:0] clamped;
  logic             idle;
  logic             take_start;

  assign idle       = (st_q == ST_IDLE);
  assign clamped    = (count_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : count_i;
  assign do_load    = idle && load_i;
  assign take_start = idle && !load_i && start_i;
  assign do_riffle  = (st_q == ST_RIFFLE);
  assign do_perm    = (st_q == ST_PERM);
  assign valid_o    = (st_q == ST_STREAM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= CNT_W'(DEPTH);
      sel_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_PERM);
      case (st_q)
        ST_IDLE: begin
          if (do_load) begin
            cnt_q <= clamped;
          end else if (take_start) begin
            sel_q <= rng_i;
            st_q  <= ST_RIFFLE;
          end
        end
        ST_RIFFLE: st_q <= ST_PERM;
        ST_PERM: begin
          beat_q <= '0;
          st_q   <= ST_STREAM;
        end
        default: begin
          if (ready_i) begin
            beat_q <= beat_q + 2'd1;
            if (beat_q == 2'd3) st_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign sel_o  = sel_q;
  assign beat_o = beat_q;
  assign done_o = done_q;
endmodule

// File: rtl/match_idx_shuffler.sv
module match_idx_shuffler #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] pt_count_i,
  input  logic             start_i,
  input  logic             nib_vld_i,
  input  logic [3:0]       nib_i,
  output logic             done_o,
  output logic             smp_valid_o,
  input  logic             smp_ready_i,
  output logic [IDX_W-1:0] smp_idx_o
);
  logic [3:0]       misr_q;
  logic             do_load, do_riffle, do_perm;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       sel_q;
  logic [1:0]       beat_q;

  sig_reg4 #(.SEED(4'b0001)) u_misr (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (nib_vld_i),
    .in_nib  (nib_i),
    .state_o (misr_q)
  );

  shuf_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .start_i   (start_i),
    .count_i   (pt_count_i),
    .rng_i     (misr_q[2:0]),
    .ready_i   (smp_ready_i),
    .do_load   (do_load),
    .do_riffle (do_riffle),
    .do_perm   (do_perm),
    .cnt_o     (cnt_q),
    .sel_o     (sel_q),
    .beat_o    (beat_q),
    .valid_o   (smp_valid_o),
    .done_o    (done_o)
  );

  idx_file #(.DEPTH(DEPTH)) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_load   (do_load),
    .do_riffle (do_riffle),
    .do_perm   (do_perm),
    .cnt_i     (cnt_q),
    .sel_i     (sel_q),
    .rd_addr   (beat_q),
    .rd_data   (smp_idx_o)
  );
endmodule

// File: rtl/shuf_chk.sv
module shuf_chk #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             ready,
  input logic [IDX_W-1:0] idx,
  input logic             done,
  input logic             nib_vld,
  input logic [3:0]       misr,
  input logic [CNT_W-1:0] cnt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(idx)) else $error("stall hold"); // R7

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid) else $error("done without valid"); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R6

  AST_VALID_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> done) else $error("valid rose without done"); // R6

  AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_vld |=> $stable(misr)) else $error("misr moved"); // R2

  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(cnt)) else $error("count changed in stream"); // R1

  AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (cnt >= CNT_W'(4)) |-> ({1'b0, idx} < cnt)) else $error("index outside list"); // R4
endmodule

bind match_idx_shuffler shuf_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid   (smp_valid_o),
  .ready   (smp_ready_i),
  .idx     (smp_idx_o),
  .done    (done_o),
  .nib_vld (nib_vld_i),
  .misr    (misr_q),
  .cnt     (cnt_q)
);

// File: tb/sim_match_idx_shuffler.sv
module sim_match_idx_shuffler;
  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, start_i = 1'b0, nib_vld_i = 1'b0, smp_ready_i = 1'b1;
  logic [CNT_W-1:0] pt_count_i = '0;
  logic [3:0] nib_i = '0;
  logic done_o, smp_valid_o;
  logic [IDX_W-1:0] smp_idx_o;

  always #2 clk = ~clk;

  match_idx_shuffler #(.DEPTH(DEPTH)) u0 (.*);

  int total = 0, fails = 0;
  int model [DEPTH];
  int ecount = DEPTH;
  logic [3:0] m = 4'b0001;
  int expq [$];
  int rmode = 0;
  logic [7:0] lf = 8'hA5;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pmap(input int s, input int k);
    int t [8][4] = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1}, '{3,2,1,0},
                     '{1,2,3,0}, '{3,0,1,2}, '{0,2,1,3}, '{2,0,3,1}};
    return t[s][k];
  endfunction

  // ready driver
  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (rmode == 0)      smp_ready_i = 1'b1;
    else if (rmode == 1) smp_ready_i = lf[0] | lf[2];
    else                 smp_ready_i = 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && smp_valid_o && smp_ready_i) begin
      if (expq.size() == 0) check(1'b0, "R7 unexpected beat", int'(smp_idx_o), -1);
      else begin
        int e;
        e = expq.pop_front();
        check(int'(smp_idx_o) == e, "R3/R4/R7 sample", int'(smp_idx_o), e);
      end
    end
  end

  task automatic do_load(input int n);
    @(posedge clk); #1;
    load_i = 1'b1; pt_count_i = CNT_W'(n);
    @(posedge clk); #1;
    load_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = i;
    ecount = (n > DEPTH) ? DEPTH : n;
  endtask

  task automatic feed(input logic [3:0] v);
    @(posedge clk); #1;
    nib_vld_i = 1'b1; nib_i = v;
    @(posedge clk); #1;
    nib_vld_i = 1'b0;
    m = {m[2:0], m[3] ^ m[2]} ^ v;
  endtask

  task automatic kick();
    int old [DEPTH];
    int h, snap;
    snap = int'(m[2:0]);
    old = model;
    h = ecount / 2;
    for (int i = 0; i < h; i++) begin
      model[2*i]   = old[i];
      model[2*i+1] = old[h+i];
    end
    old = model;
    for (int g = 0; 4*g + 4 <= ecount; g++) begin
      int s;
      s = snap ^ (g % 8);
      for (int k = 0; k < 4; k++) model[4*g+k] = old[4*g + pmap(s, k)];
    end
    for (int k = 0; k < 4; k++) expq.push_back(model[k]);
    @(posedge clk); #1;
    start_i = 1'b1;
    @(posedge clk); #1;       // edge k taken
    start_i = 1'b0;
    check(done_o == 1'b0, "R6 done early", int'(done_o), 0);
    @(posedge clk); #1;       // k+1
    check(done_o == 1'b0, "R6 done early", int'(done_o), 0);
    @(posedge clk); #1;       // k+2
    check(done_o == 1'b1, "R6 done pulse", int'(done_o), 1);
    check(smp_valid_o == 1'b1, "R6 valid with done", int'(smp_valid_o), 1);
    @(posedge clk); #1;
    check(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((smp_valid_o || expq.size() != 0) && guard < 1000) begin
      @(posedge clk); #1; guard++;
    end
    check(expq.size() == 0 && !smp_valid_o, "R7 stream finished", expq.size(), 0);
  endtask

  task automatic shuffle();
    kick();
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!smp_valid_o && !done_o, "R8 reset outputs", int'({smp_valid_o, done_o}), 0);

    // R1 R3 R4: full list, repeated starts accumulate (R5)
    do_load(64);
    feed(4'h6); feed(4'hB);
    shuffle();
    feed(4'h3);
    shuffle();
    shuffle();                                   // R5 no reseed, no load

    // back-pressure (R7) with a short even list
    rmode = 1;
    do_load(10);
    feed(4'h9); shuffle();
    feed(4'h2); shuffle();

    // odd count (R3)
    do_load(7);
    feed(4'hE); shuffle(); shuffle();

    // clamp (R1) and minimum lists
    do_load(100);
    feed(4'h1); shuffle();
    do_load(4);
    feed(4'h7); shuffle();
    do_load(5); shuffle();
    do_load(3); shuffle();

    // R1: load and start during a stalled stream are ignored
    rmode = 0;
    do_load(12);
    feed(4'hC);
    rmode = 2;
    kick();
    @(posedge clk); #1;
    load_i = 1'b1; start_i = 1'b1; pt_count_i = CNT_W'(8);
    @(posedge clk); #1;
    load_i = 1'b0; start_i = 1'b0;
    rmode = 0;
    wait_idle();
    shuffle();                                   // R1 still 12 entries, not reset

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule